// File: doc/BRIEF.md
# Paged Program Counter with Subroutine Call Unit

This block keeps the 15-bit program counter of a small microcontroller core together with a 16-entry hardware return stack. The instruction decoder pulses one strobe per cycle to request an operation:
- an immediate call, whose 11-bit operand gives the low target bits;
- a register call, whose low target byte comes from the working register;
- a return;
- a stall.

In both call forms the remaining upper target bits come from a 7-bit page latch, each form using its own slice of that latch. With no strobe, the counter advances by one.

Every call writes the address that follows the calling instruction onto the return stack and then loads the assembled target. A call occupies two cycles. The second cycle is a pipeline flush in which the counter holds and every strobe is ignored. A return pops the newest entry straight into the counter in a single cycle. Two sticky flags report a push to a full stack and a pop from an empty one. Both flags stay set until reset.

Top module: `pc_call_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pc_o` is 0, `depth_o` is 0, and `flush_o`, `ovf_o` and `unf_o` are 0.
- R2: In a cycle that is not a flush cycle and has no strobe, `pc_o` becomes `pc_o`+1 modulo 2^15, so 0x7FFF is followed by 0x0000.
- R3: A `stall_i` cycle that is not a flush cycle and has no other strobe leaves `pc_o` and `depth_o` unchanged.
- R4: An accepted immediate call loads `pc_o` with {`page_i[6:3]`, `imm_i[10:0]`}.
- R5: An accepted register call loads `pc_o` with {`page_i[6:0]`, `wreg_i[7:0]`}.
- R6: Every accepted call pushes (`pc_o`+1) modulo 2^15, taken from the cycle of the call, and `depth_o` grows by one if the stack is not full.
- R7: The cycle after an accepted call is a flush cycle. In it `flush_o` is 1, `pc_o` and `depth_o` hold, and all strobes are ignored. `flush_o` is 0 in every other cycle.
- R8: A return with `depth_o` > 0 loads `pc_o` with the newest stack entry and lowers `depth_o` by one, all in one cycle.
- R9: When several strobes are high in a non-flush cycle, only one is acted on. The order from highest to lowest is immediate call, register call, return, stall.
- R10: A call made while `depth_o` is 16 sets `ovf_o`, which then stays 1 until reset. The stack is left unchanged, and the call still loads its target and flushes.
- R11: A return made while `depth_o` is 0 sets `unf_o`, which then stays 1 until reset. It also loads `pc_o` with 0 and leaves `depth_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_imm_i | input | 1 | Immediate call strobe |
| call_reg_i | input | 1 | Register call strobe |
| ret_i | input | 1 | Return strobe |
| stall_i | input | 1 | Hold the counter this cycle |
| imm_i | input | 11 | Call operand from the instruction |
| wreg_i | input | 8 | Working register value |
| page_i | input | 7 | Page latch value |
| pc_o | output | 15 | Program counter |
| depth_o | output | 5 | Number of occupied stack entries (0 to 16) |
| flush_o | output | 1 | High during the flush cycle of a call |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The sharpest collision is a call issued while the stack already holds 16 entries. In that cycle the counter must load the call target while the stack refuses the push and raises the overflow flag. The bench provokes it with a directed run of back-to-back immediate calls whose strobe stays high through the flush cycles, and again during long random stretches. A second collision is several strobes in one cycle, which the bench drives both directly and at random. A cycle-accurate model in the bench, covering the counter, the stack contents and both sticky flags, judges every cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned PC_W_DEF   = 15;
  localparam int unsigned IMM_W_DEF  = 11;
  localparam int unsigned W_W_DEF    = 8;
  localparam int unsigned PAGE_W_DEF = 7;
  localparam int unsigned DEPTH_DEF  = 16;

  typedef enum logic [2:0] {
    OP_NEXT     = 3'd0,
    OP_CALL_IMM = 3'd1,
    OP_CALL_REG = 3'd2,
    OP_RET      = 3'd3,
    OP_HOLD     = 3'd4,
    OP_FLUSH    = 3'd5
  } pcu_op_e;

  function automatic logic is_call(input pcu_op_e op);
    return (op == OP_CALL_IMM) || (op == OP_CALL_REG);
  endfunction
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic    flush_i,
  input  logic    call_imm_i,
  input  logic    call_reg_i,
  input  logic    ret_i,
  input  logic    stall_i,
  output pcu_op_e op_o
);
  always_comb begin
    if (flush_i)         op_o = OP_FLUSH;
    else if (call_imm_i) op_o = OP_CALL_IMM;
    else if (call_reg_i) op_o = OP_CALL_REG;
    else if (ret_i)      op_o = OP_RET;
    else if (stall_i)    op_o = OP_HOLD;
    else                 op_o = OP_NEXT;
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int unsigned PC_W   = 15,
  parameter int unsigned IMM_W  = 11,
  parameter int unsigned W_W    = 8,
  parameter int unsigned PAGE_W = 7
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [W_W-1:0]    wreg_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   tgt_imm_o,
  output logic [PC_W-1:0]   tgt_reg_o
);
  localparam int unsigned IMM_HI = PC_W - IMM_W;
  localparam int unsigned REG_HI = PC_W - W_W;

  // the immediate form draws its page bits from the top of the latch
  assign tgt_imm_o = {page_i[PAGE_W-1 -: IMM_HI], imm_i};
  // the register form draws its page bits from the bottom of the latch
  assign tgt_reg_o = {page_i[REG_HI-1:0], wreg_i};
endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int unsigned PC_W  = 15,
  parameter int unsigned DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] wdata_i,
  output logic [PC_W-1:0] tos_o,
  output logic            empty_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [PC_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]   cnt_q;
  logic            full;
  logic [CW-1:0]   top_c;
  logic [AW-1:0]   top_idx;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_c   = cnt_q - CW'(1);
  assign top_idx = top_c[AW-1:0];
  assign tos_o   = mem_q[top_idx];
  assign depth_o = cnt_q;

  // storage without reset: one write port, one read port
  always_ff @(posedge clk) begin
    if (push_i && !full) mem_q[cnt_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (push_i) begin
        if (full) ovf_o <= 1'b1;
        else      cnt_q <= cnt_q + CW'(1);
      end else if (pop_i) begin
        if (empty_o) unf_o <= 1'b1;
        else         cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o); // R10
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> unf_o); // R11
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !empty_o) |=> cnt_q == $past(cnt_q) - CW'(1)); // R8
  AST_FULL_PUSH_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (push_i && full) |=> (ovf_o && cnt_q == CW'(DEPTH))); // R10
endmodule

// File: rtl/pcu_seq.sv
module pcu_seq
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  pcu_op_e         op_i,
  input  logic [PC_W-1:0] tgt_imm_i,
  input  logic [PC_W-1:0] tgt_reg_i,
  input  logic [PC_W-1:0] tos_i,
  input  logic            empty_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pc_inc_o,
  output logic            flush_o
);
  assign pc_inc_o = pc_o + PC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o    <= '0;
      flush_o <= 1'b0;
    end else begin
      flush_o <= is_call(op_i);
      unique case (op_i)
        OP_CALL_IMM: pc_o <= tgt_imm_i;
        OP_CALL_REG: pc_o <= tgt_reg_i;
        OP_RET:      pc_o <= empty_i ? '0 : tos_i;
        OP_NEXT:     pc_o <= pc_inc_o;
        default:     pc_o <= pc_o;
      endcase
    end
  end

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o); // R7
  AST_FLUSH_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> pc_o == $past(pc_o)); // R7
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RET && empty_i) |=> pc_o == '0); // R11
endmodule

// File: rtl/pc_call_unit.sv
module pc_call_unit
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W   = PC_W_DEF,
  parameter int unsigned IMM_W  = IMM_W_DEF,
  parameter int unsigned W_W    = W_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       call_imm_i,
  input  logic                       call_reg_i,
  input  logic                       ret_i,
  input  logic                       stall_i,
  input  logic [IMM_W-1:0]           imm_i,
  input  logic [W_W-1:0]             wreg_i,
  input  logic [PAGE_W-1:0]          page_i,
  output logic [PC_W-1:0]            pc_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       flush_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int unsigned IMM_HI = PC_W - IMM_W;
  localparam int unsigned REG_HI = PC_W - W_W;

  pcu_op_e         op;
  logic [PC_W-1:0] tgt_imm, tgt_reg, tos, pc_inc;
  logic            empty;

  pcu_decode u_dec (
    .flush_i(flush_o), .call_imm_i(call_imm_i), .call_reg_i(call_reg_i),
    .ret_i(ret_i), .stall_i(stall_i), .op_o(op)
  );

  pcu_target #(.PC_W(PC_W), .IMM_W(IMM_W), .W_W(W_W), .PAGE_W(PAGE_W)) u_tgt (
    .imm_i(imm_i), .wreg_i(wreg_i), .page_i(page_i),
    .tgt_imm_o(tgt_imm), .tgt_reg_o(tgt_reg)
  );

  pcu_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push_i(is_call(op)), .pop_i(op == OP_RET),
    .wdata_i(pc_inc), .tos_o(tos), .empty_o(empty), .depth_o(depth_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  pcu_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst(rst), .op_i(op), .tgt_imm_i(tgt_imm), .tgt_reg_i(tgt_reg),
    .tos_i(tos), .empty_i(empty), .pc_o(pc_o), .pc_inc_o(pc_inc), .flush_o(flush_o)
  );

  AST_IMM_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!flush_o && call_imm_i) |=>
      pc_o == {$past(page_i[PAGE_W-1 -: IMM_HI]), $past(imm_i)}); // R4
  AST_REG_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!flush_o && !call_imm_i && call_reg_i) |=>
      pc_o == {$past(page_i[REG_HI-1:0]), $past(wreg_i)}); // R5
  AST_CALL_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    (!flush_o && (call_imm_i || call_reg_i)) |=> flush_o); // R7
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!flush_o && !call_imm_i && !call_reg_i && !ret_i && !stall_i) |=>
      pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flush_o && !call_imm_i && !call_reg_i && !ret_i && stall_i) |=>
      (pc_o == $past(pc_o) && depth_o == $past(depth_o))); // R3
endmodule

// File: tb/pc_call_unit_tb.sv
module pc_call_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_imm_i = 0, call_reg_i = 0, ret_i = 0, stall_i = 0;
  logic [10:0] imm_i = '0;
  logic [7:0]  wreg_i = '0;
  logic [6:0]  page_i = '0;
  logic [14:0] pc_o;
  logic [4:0]  depth_o;
  logic        flush_o, ovf_o, unf_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  logic [14:0] m_pc;
  logic [14:0] m_stk [DEPTH];
  int          m_cnt;
  bit          m_flush, m_ovf, m_unf;
  string       tag;

  always #(CLK_P/2) clk = ~clk;

  pc_call_unit dut_i (
    .clk(clk), .rst(rst), .call_imm_i(call_imm_i), .call_reg_i(call_reg_i),
    .ret_i(ret_i), .stall_i(stall_i), .imm_i(imm_i), .wreg_i(wreg_i),
    .page_i(page_i), .pc_o(pc_o), .depth_o(depth_o), .flush_o(flush_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic cmp(input int act, input int exp, input string t, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string t);
    cmp(int'(pc_o), int'(m_pc), t, "pc");
    cmp(int'(depth_o), m_cnt, t, "depth");
    cmp(int'(flush_o), int'(m_flush), t, "flush R7");
    cmp(int'(ovf_o), int'(m_ovf), t, "ovf R10");
    cmp(int'(unf_o), int'(m_unf), t, "unf R11");
  endtask

  function automatic void model_push(input logic [14:0] v);
    if (m_cnt == DEPTH) begin m_ovf = 1; tag = "R10"; end
    else begin m_stk[m_cnt] = v; m_cnt++; end
  endfunction

  function automatic void model_step();
    int nstb;
    nstb = int'(call_imm_i) + int'(call_reg_i) + int'(ret_i) + int'(stall_i);
    if (m_flush) begin
      m_flush = 0; tag = "R7";
    end else if (call_imm_i) begin
      tag = (nstb > 1) ? "R9" : "R4,R6";
      model_push(m_pc + 15'd1);
      m_pc = {page_i[6:3], imm_i}; m_flush = 1;
    end else if (call_reg_i) begin
      tag = (nstb > 1) ? "R9" : "R5,R6";
      model_push(m_pc + 15'd1);
      m_pc = {page_i, wreg_i}; m_flush = 1;
    end else if (ret_i) begin
      if (m_cnt == 0) begin m_unf = 1; m_pc = '0; tag = "R11"; end
      else begin m_cnt--; m_pc = m_stk[m_cnt]; tag = (nstb > 1) ? "R9" : "R6,R8"; end
    end else if (stall_i) begin
      tag = "R3";
    end else begin
      m_pc = m_pc + 15'd1; tag = "R2";
    end
  endfunction

  task automatic cycle(input bit ci, input bit cr, input bit rt, input bit st,
                       input logic [10:0] im, input logic [7:0] w, input logic [6:0] pg);
    @(negedge clk);
    call_imm_i = ci; call_reg_i = cr; ret_i = rt; stall_i = st;
    imm_i = im; wreg_i = w; page_i = pg;
    model_step();
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; call_imm_i = 0; call_reg_i = 0; ret_i = 0; stall_i = 0;
    m_pc = '0; m_cnt = 0; m_flush = 0; m_ovf = 0; m_unf = 0;
    repeat (2) @(posedge clk);
    #1; check_all("R1");
    @(negedge clk); rst = 0;
    @(posedge clk); #1; m_pc = 15'd1; check_all("R1");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    repeat (3) cycle(0, 0, 0, 0, '0, '0, '0);          // R2 stepping
    cycle(0, 0, 1, 0, '0, '0, '0);                      // R11 pop empty
    cycle(0, 0, 0, 0, '0, '0, '0);
    cycle(0, 0, 0, 1, '0, '0, '0);                      // R3 stall

    do_reset();
    cycle(0, 1, 0, 0, 11'h155, 8'hFF, 7'h7F);           // R5 target 7FFF
    cycle(1, 1, 1, 1, 11'h7FF, 8'h00, 7'h00);           // R7 all ignored
    cycle(0, 0, 0, 0, '0, '0, '0);                      // R2 wrap to 0
    cycle(1, 1, 1, 1, 11'h2A5, 8'h3C, 7'b1010011);      // R9 imm wins, R4 slice
    cycle(0, 0, 0, 0, '0, '0, '0);
    cycle(0, 1, 1, 1, 11'h001, 8'hC3, 7'h5A);           // R9 reg wins
    cycle(0, 0, 0, 0, '0, '0, '0);
    cycle(0, 0, 1, 1, '0, '0, '0);                      // R9 ret over stall, R8
    cycle(0, 0, 1, 0, '0, '0, '0);                      // R8
    cycle(0, 0, 0, 0, '0, '0, '0);

    // R10: back-to-back calls, strobe held through flush cycles
    for (int i = 0; i < 2 * (DEPTH + 3); i++)
      cycle(1, 0, 0, 0, 11'(i * 37), '0, 7'(i));
    for (int i = 0; i < DEPTH + 2; i++)
      cycle(0, 0, 1, 0, '0, '0, '0);                    // R8 drain then R11

    do_reset();
    for (int i = 0; i < 6000; i++) begin
      int r;
      bit ci, cr, rt, st;
      r = $urandom_range(0, 99);
      ci = (r < 11); cr = (r >= 11 && r < 22); rt = (r >= 22 && r < 42);
      st = (r >= 42 && r < 50);
      if (r >= 95) begin
        ci = 1'($urandom); cr = 1'($urandom); rt = 1'($urandom); st = 1'($urandom);
      end
      cycle(ci, cr, rt, st, 11'($urandom), 8'($urandom), 7'($urandom));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule